// File: doc/BRIEF.md
# Demodulator Configuration Front End

This block sits between a byte-wide register bus and a satellite QPSK/BPSK demodulator. It holds the master configuration byte and enforces the bring-up order. The configuration byte must be written first. After that a fixed settling interval must pass before the demodulator's soft-reset register may be written. A write that breaks this order is dropped and raises a sticky error flag.

From the configuration byte and a small bank of programmable registers, the block works out the operating parameters that the demodulator core uses:

- the system clock in half-MHz units, taken from a software override or computed from the crystal and PLL-factor fields;
- the symbol rate;
- the roll-off selection;
- the code-rate source and the effective code rate.

When a DSS mode is selected, the symbol rate, the roll-off and the code rate are forced, and the values software has written are ignored.

The configuration byte can be returned to its default only by the hardware reset pin. The settling interval is given in microseconds and is counted in reference-clock cycles. With the default parameters it is N = 9000 cycles; the bench uses N = 20. All writes take effect on the clock edge that samples them, and the derived outputs follow combinationally from the stored values.

Top module: `demod_cfg_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following are cleared: `cfg_valid`, `order_err` and `soft_rst_pulse`. The configuration byte returns to 0x00, so `demod_enable`=0 and `sysclk_half_mhz`=60.
- R2: The configuration byte (address 0x00) is decoded as follows. Bit 7 drives `demod_enable`. Bit 4 drives `bpsk_sel` (1 = BPSK). Bit 1 drives `xtal_15m` (1 = 15 MHz, 0 = 10 MHz). Bit 0 drives `ext_adc_sel` (1 = external ADC). Bits 6:5 drive `code_rate_src`.
- R3: Bits 3:2 of the configuration byte select the PLL ratio `pll_ratio`: 00→3, 01→4, 10→6, 11→9. When the override register is zero, `sysclk_half_mhz` = 2 × crystal MHz × ratio.
- R4: When the clock-override register (address 0x02) holds a nonzero value, `sysclk_half_mhz` equals that value.
- R5: Before the first configuration write, any write to any other address is dropped and sets `order_err`.
- R6: A write to the reset register (address 0x01) is accepted only if it is sampled at least N+1 edges after the edge that stored the configuration. An accepted write gives a one-cycle `soft_rst_pulse`. An earlier write is dropped and sets `order_err`.
- R7: Rewriting the configuration byte restarts the settling wait.
- R8: When `code_rate_src` is nonzero (a DSS mode), `sym_rate_eff` is 20000 (kbaud) and `rolloff_eff` is 2'b10 (forced 0.20).
- R9: In DVB mode (`code_rate_src`=00), the outputs come from the programmable registers. `sym_rate_eff` = {reg 0x03, reg 0x04}. `rolloff_eff` = {0, bit 0 of reg 0x05}. `code_rate_eff` = bits 2:0 of reg 0x06.
- R10: In DSS modes the code-rate register is ignored. `code_rate_eff` is 3'd1 (2/3) for source 01, 3'd5 (6/7) for source 10, and 3'd7 (search) for source 11.
- R11: `cfg_valid` and `order_err`, once set, stay set until `rst_n` is low.
- R12: A write takes effect at the edge that samples it. Writing 0x88 gives the following: enabled, QPSK, internal ADC, 10 MHz crystal, ratio 6 and `sysclk_half_mhz`=120.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data |
| cfg_valid | output | 1 | Configuration has been loaded |
| demod_enable | output | 1 | Demodulator enabled (0 = power-down) |
| bpsk_sel | output | 1 | 1 = BPSK, 0 = QPSK |
| ext_adc_sel | output | 1 | 1 = external ADC |
| xtal_15m | output | 1 | 1 = 15 MHz crystal |
| pll_ratio | output | 4 | PLL multiplication ratio |
| sysclk_half_mhz | output | 9 | Effective system clock, half-MHz units |
| sym_rate_eff | output | 16 | Effective symbol rate, kbaud |
| rolloff_eff | output | 2 | Roll-off select (00/01 programmed, 10 forced 0.20) |
| code_rate_src | output | 2 | 00 DVB, 01 DSS 2/3, 10 DSS 6/7, 11 DSS search |
| code_rate_eff | output | 3 | Effective code-rate code |
| soft_rst_pulse | output | 1 | One-cycle pulse on an accepted reset-register write |
| order_err | output | 1 | Sticky write-order violation |

## Verification
The assertions assume that the bus presents at most one write per cycle and that `wr_addr` and `wr_en` hold known values once reset is released. The settling check also assumes that the configuration byte is the only thing that restarts the wait. The stimulus meets these assumptions by driving every bus field on the falling edge from a single task, with one write per call and idle cycles between calls. The configuration is rewritten only at the points where the bench deliberately tests the restart of the wait.

// File: rtl/demod_cfg_pkg.sv
// Package: shared field layout, mode encodings and helper functions for the
// demodulator configuration front end. Assumes an 8-bit configuration byte.
package demod_cfg_pkg;

    // Layout of the configuration byte, MSB first
    typedef struct packed {
        logic       enable;
        logic [1:0] dss;
        logic       bpsk;
        logic [1:0] pll_code;
        logic       xtal15;
        logic       adc_ext;
    } cfg_fields_t;

    typedef enum logic [1:0] {
        SRC_DVB    = 2'b00,
        SRC_DSS_23 = 2'b01,
        SRC_DSS_67 = 2'b10,
        SRC_SEARCH = 2'b11
    } rate_src_e;

    localparam logic [1:0] RO_PROG0  = 2'b00;
    localparam logic [1:0] RO_PROG1  = 2'b01;
    localparam logic [1:0] RO_FIX020 = 2'b10;

    localparam logic [2:0] CR_TWO_THIRDS = 3'd1;
    localparam logic [2:0] CR_SIX_SEVEN  = 3'd5;
    localparam logic [2:0] CR_SEARCH     = 3'd7;

    // Nonlinear PLL-factor code to multiplication ratio
    function automatic logic [3:0] pll_ratio_of(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd3;
            2'b01:   return 4'd4;
            2'b10:   return 4'd6;
            default: return 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/cfg_write_guard.sv
// Module: cfg_write_guard
// Enforces the write order. The configuration byte comes first. The reset
// register is then held off for SETTLE_CYCLES cycles. Writes that break the
// order are dropped and raise a sticky error. Assumes at most one write per
// cycle and a synchronous active-low reset.
module cfg_write_guard #(
    parameter int ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] ADDR_CFG = '0,
    parameter logic [ADDR_W-1:0] ADDR_RST = 1,
    parameter int SETTLE_CYCLES = 9000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              cfg_we,
    output logic              prog_we,
    output logic              cfg_valid,
    output logic              order_err,
    output logic              soft_rst_pulse
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);

    logic [CNT_W-1:0] wait_cnt;
    logic             hit_cfg;
    logic             hit_rst;
    logic             settled;
    logic             rst_ok;
    logic             violation;

    // Address decode and acceptance rules
    always_comb begin
        hit_cfg   = (wr_addr == ADDR_CFG);
        hit_rst   = (wr_addr == ADDR_RST);
        settled   = cfg_valid && (wait_cnt == '0);
        cfg_we    = wr_en && hit_cfg;
        rst_ok    = wr_en && hit_rst && settled;
        prog_we   = wr_en && !hit_cfg && !hit_rst && cfg_valid;
        violation = wr_en && !hit_cfg && (!cfg_valid || (hit_rst && !settled));
    end

    // Settling counter, reloaded by every configuration write
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_cnt <= '0;
        else if (cfg_we)
            wait_cnt <= CNT_LOAD;
        else if (wait_cnt != '0)
            wait_cnt <= wait_cnt - 1'b1;
    end

    // Sticky flags and the soft-reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_valid      <= 1'b0;
            order_err      <= 1'b0;
            soft_rst_pulse <= 1'b0;
        end else begin
            cfg_valid      <= cfg_valid | cfg_we;
            order_err      <= order_err | violation;
            soft_rst_pulse <= rst_ok;
        end
    end

endmodule

// File: rtl/cfg_reg_bank.sv
// Module: cfg_reg_bank
// Storage for the configuration byte and a run of NUM_PROG programmable bytes
// placed at consecutive addresses from PROG_BASE. Only the reset pin restores
// the configuration byte. Write enables come pre-qualified from the guard.
module cfg_reg_bank #(
    parameter int ADDR_W    = 8,
    parameter int NUM_PROG  = 5,
    parameter logic [ADDR_W-1:0] PROG_BASE = 2,
    parameter logic [7:0] CFG_DEFAULT = 8'h00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic                   prog_we,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    output logic [7:0]             cfg_byte,
    output logic [NUM_PROG*8-1:0]  prog_bytes
);
    // Configuration byte store
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_byte <= CFG_DEFAULT;
        else if (cfg_we)
            cfg_byte <= wr_data;
    end

    // One byte register per programmable address
    for (genvar gi = 0; gi < NUM_PROG; gi++) begin : g_prog
        localparam logic [ADDR_W-1:0] MY_ADDR = PROG_BASE + ADDR_W'(gi);
        logic [7:0] val_q;

        // Load this byte when its address is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= 8'h00;
            else if (prog_we && (wr_addr == MY_ADDR))
                val_q <= wr_data;
        end

        assign prog_bytes[gi*8 +: 8] = val_q;
    end

endmodule

// File: rtl/cfg_clk_resolve.sv
// Module: cfg_clk_resolve
// Resolves the effective system clock in half-MHz units. A nonzero override
// byte wins. Otherwise the clock is 2 x crystal MHz x PLL ratio. Purely
// combinational.
module cfg_clk_resolve
    import demod_cfg_pkg::*;
#(
    parameter int XTAL_LO_MHZ = 10,
    parameter int XTAL_HI_MHZ = 15
) (
    input  logic [1:0] pll_code,
    input  logic       xtal15,
    input  logic [7:0] override_val,
    output logic [3:0] pll_ratio,
    output logic [8:0] sysclk_half_mhz
);
    localparam logic [5:0] HALF_LO = 6'(2 * XTAL_LO_MHZ);
    localparam logic [5:0] HALF_HI = 6'(2 * XTAL_HI_MHZ);

    logic [5:0] xtal_half;
    logic [9:0] product;

    // Crystal times ratio, or the software override
    always_comb begin
        pll_ratio = pll_ratio_of(pll_code);
        xtal_half = xtal15 ? HALF_HI : HALF_LO;
        product   = 10'(xtal_half) * 10'(pll_ratio);
        if (override_val != 8'h00)
            sysclk_half_mhz = {1'b0, override_val};
        else
            sysclk_half_mhz = product[8:0];
    end

endmodule

// File: rtl/cfg_param_resolve.sv
// Module: cfg_param_resolve
// Resolves the symbol rate, the roll-off and the code rate. In any DSS mode
// these are forced and the programmed registers are ignored. Purely
// combinational.
module cfg_param_resolve
    import demod_cfg_pkg::*;
#(
    parameter logic [15:0] FORCED_SYM = 16'd20000
) (
    input  logic [1:0]  dss,
    input  logic [7:0]  sym_hi,
    input  logic [7:0]  sym_lo,
    input  logic [7:0]  demod_ctrl,
    input  logic [7:0]  rate_reg,
    output logic [15:0] sym_rate_eff,
    output logic [1:0]  rolloff_eff,
    output logic [2:0]  code_rate_eff
);
    rate_src_e src;

    // Apply the DSS overrides on top of the programmed values
    always_comb begin
        src = rate_src_e'(dss);
        if (src == SRC_DVB) begin
            sym_rate_eff = {sym_hi, sym_lo};
            rolloff_eff  = demod_ctrl[0] ? RO_PROG1 : RO_PROG0;
        end else begin
            sym_rate_eff = FORCED_SYM;
            rolloff_eff  = RO_FIX020;
        end
        case (src)
            SRC_DSS_23: code_rate_eff = CR_TWO_THIRDS;
            SRC_DSS_67: code_rate_eff = CR_SIX_SEVEN;
            SRC_SEARCH: code_rate_eff = CR_SEARCH;
            default:    code_rate_eff = rate_reg[2:0];
        endcase
    end

endmodule

// File: rtl/demod_cfg_regs.sv
// Module: demod_cfg_regs (top)
// Register front end for a satellite demodulator. It takes bus writes,
// enforces the configure/settle/reset order and presents the resolved
// operating parameters. Writes land on the sampling edge. The outputs follow
// combinationally from the stored values.
module demod_cfg_regs
    import demod_cfg_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int REF_CLK_KHZ = 60000,
    parameter int SETTLE_US   = 150,
    parameter logic [7:0] CFG_DEFAULT = 8'h00,
    parameter logic [15:0] FORCED_SYM = 16'd20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              cfg_valid,
    output logic              demod_enable,
    output logic              bpsk_sel,
    output logic              ext_adc_sel,
    output logic              xtal_15m,
    output logic [3:0]        pll_ratio,
    output logic [8:0]        sysclk_half_mhz,
    output logic [15:0]       sym_rate_eff,
    output logic [1:0]        rolloff_eff,
    output logic [1:0]        code_rate_src,
    output logic [2:0]        code_rate_eff,
    output logic              soft_rst_pulse,
    output logic              order_err
);
    localparam int SETTLE_CYCLES = (REF_CLK_KHZ * SETTLE_US + 999) / 1000;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_RST  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PROG_BASE = ADDR_W'(2);
    localparam int NUM_PROG  = 5;
    localparam int IDX_OVR   = 0;
    localparam int IDX_SYMHI = 1;
    localparam int IDX_SYMLO = 2;
    localparam int IDX_CTRL  = 3;
    localparam int IDX_RATE  = 4;

    logic                  cfg_we;
    logic                  prog_we;
    logic [7:0]            cfg_byte;
    logic [NUM_PROG*8-1:0] prog_bytes;
    cfg_fields_t           cfg_f;

    cfg_write_guard #(
        .ADDR_W(ADDR_W), .ADDR_CFG(ADDR_CFG), .ADDR_RST(ADDR_RST),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) guard_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .cfg_we(cfg_we), .prog_we(prog_we), .cfg_valid(cfg_valid),
        .order_err(order_err), .soft_rst_pulse(soft_rst_pulse)
    );

    cfg_reg_bank #(
        .ADDR_W(ADDR_W), .NUM_PROG(NUM_PROG), .PROG_BASE(PROG_BASE),
        .CFG_DEFAULT(CFG_DEFAULT)
    ) bank_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .prog_we(prog_we),
        .wr_addr(wr_addr), .wr_data(wr_data), .cfg_byte(cfg_byte),
        .prog_bytes(prog_bytes)
    );

    // Field view of the configuration byte
    always_comb begin
        cfg_f         = cfg_fields_t'(cfg_byte);
        demod_enable  = cfg_f.enable;
        bpsk_sel      = cfg_f.bpsk;
        ext_adc_sel   = cfg_f.adc_ext;
        xtal_15m      = cfg_f.xtal15;
        code_rate_src = cfg_f.dss;
    end

    cfg_clk_resolve clk_res_i (
        .pll_code(cfg_f.pll_code), .xtal15(cfg_f.xtal15),
        .override_val(prog_bytes[IDX_OVR*8 +: 8]),
        .pll_ratio(pll_ratio), .sysclk_half_mhz(sysclk_half_mhz)
    );

    cfg_param_resolve #(.FORCED_SYM(FORCED_SYM)) par_res_i (
        .dss(cfg_f.dss),
        .sym_hi(prog_bytes[IDX_SYMHI*8 +: 8]),
        .sym_lo(prog_bytes[IDX_SYMLO*8 +: 8]),
        .demod_ctrl(prog_bytes[IDX_CTRL*8 +: 8]),
        .rate_reg(prog_bytes[IDX_RATE*8 +: 8]),
        .sym_rate_eff(sym_rate_eff), .rolloff_eff(rolloff_eff),
        .code_rate_eff(code_rate_eff)
    );

endmodule

// File: rtl/demod_cfg_regs_chk.sv
// Module: demod_cfg_regs_chk
// Property checker bound to demod_cfg_regs. A saturating counter tracks the
// edges since the last configuration write, so the settling window needs no
// deep $past.
module demod_cfg_regs_chk #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_CFG = '0,
    parameter int SETTLE_CYCLES = 9000,
    parameter logic [15:0] FORCED_SYM = 16'd20000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              cfg_valid,
    input logic              order_err,
    input logic              soft_rst_pulse,
    input logic [8:0]        sysclk_half_mhz,
    input logic [15:0]       sym_rate_eff,
    input logic [1:0]        rolloff_eff,
    input logic [1:0]        code_rate_src
);
    logic [31:0] since_cfg;

    // Count edges since the last configuration write, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_cfg <= '0;
        else if (wr_en && wr_addr == ADDR_CFG)
            since_cfg <= 32'd1;
        else if (since_cfg != '0 && since_cfg != '1)
            since_cfg <= since_cfg + 32'd1;
    end

    assert_valid_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_valid);
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |=> order_err);
    assert_early_write_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_CFG && !cfg_valid) |=> order_err);
    assert_reset_after_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_pulse |-> (since_cfg >= 32'(SETTLE_CYCLES + 2)));
    assert_dss_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_rate_src != 2'b00) |-> (sym_rate_eff == FORCED_SYM && rolloff_eff == 2'b10));
    assert_sysclk_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sysclk_half_mhz != 9'd0);

endmodule

bind demod_cfg_regs demod_cfg_regs_chk #(
    .ADDR_W(ADDR_W), .ADDR_CFG(ADDR_CFG), .SETTLE_CYCLES(SETTLE_CYCLES),
    .FORCED_SYM(FORCED_SYM)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .cfg_valid(cfg_valid), .order_err(order_err), .soft_rst_pulse(soft_rst_pulse),
    .sysclk_half_mhz(sysclk_half_mhz), .sym_rate_eff(sym_rate_eff),
    .rolloff_eff(rolloff_eff), .code_rate_src(code_rate_src)
);

// File: tb/demod_cfg_regs_tb_top.sv
// Bench: sweeps every configuration byte and every override value, and
// probes the settling window at its edge. Expected values are computed here.
module demod_cfg_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic cfg_valid, demod_enable, bpsk_sel, ext_adc_sel, xtal_15m;
    logic [3:0] pll_ratio;
    logic [8:0] sysclk_half_mhz;
    logic [15:0] sym_rate_eff;
    logic [1:0] rolloff_eff, code_rate_src;
    logic [2:0] code_rate_eff;
    logic soft_rst_pulse, order_err;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    demod_cfg_regs #(.REF_CLK_KHZ(1000), .SETTLE_US(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_valid(cfg_valid), .demod_enable(demod_enable), .bpsk_sel(bpsk_sel),
        .ext_adc_sel(ext_adc_sel), .xtal_15m(xtal_15m), .pll_ratio(pll_ratio),
        .sysclk_half_mhz(sysclk_half_mhz), .sym_rate_eff(sym_rate_eff),
        .rolloff_eff(rolloff_eff), .code_rate_src(code_rate_src),
        .code_rate_eff(code_rate_eff), .soft_rst_pulse(soft_rst_pulse),
        .order_err(order_err)
    );

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    function automatic int ratio_of(input int code);
        return (code == 0) ? 3 : (code == 1) ? 4 : (code == 2) ? 6 : 9;
    endfunction

    // Full expected decode of one configuration byte with override zero
    task automatic check_cfg(input int c);
        int dss = (c >> 5) & 3;
        int r = ratio_of((c >> 2) & 3);
        int xh = ((c >> 1) & 1) ? 30 : 20;
        check("R2 enable", int'(demod_enable), (c >> 7) & 1);
        check("R2 bpsk", int'(bpsk_sel), (c >> 4) & 1);
        check("R2 xtal", int'(xtal_15m), (c >> 1) & 1);
        check("R2 adc", int'(ext_adc_sel), c & 1);
        check("R2 src", int'(code_rate_src), dss);
        check("R3 ratio", int'(pll_ratio), r);
        check("R3 sysclk", int'(sysclk_half_mhz), xh * r);
        check(dss != 0 ? "R8 sym" : "R9 sym", int'(sym_rate_eff), dss != 0 ? 20000 : 16'h1234);
        check(dss != 0 ? "R8 rolloff" : "R9 rolloff", int'(rolloff_eff), dss != 0 ? 2 : 1);
        check(dss != 0 ? "R10 rate" : "R9 rate", int'(code_rate_eff),
              dss == 0 ? 3 : dss == 1 ? 1 : dss == 2 ? 5 : 7);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        pin_reset();
        // R1 reset state
        check("R1 valid", int'(cfg_valid), 0);
        check("R1 err", int'(order_err), 0);
        check("R1 pulse", int'(soft_rst_pulse), 0);
        check("R1 enable", int'(demod_enable), 0);
        check("R1 sysclk", int'(sysclk_half_mhz), 60);

        // R5 write before configuration is dropped and flagged
        bus_write(8'h03, 8'h55);
        check("R5 err", int'(order_err), 1);
        check("R5 valid", int'(cfg_valid), 0);
        bus_write(8'h00, 8'h00);
        check("R5 dropped sym", int'(sym_rate_eff), 0);
        check("R11 err sticky", int'(order_err), 1);
        check("R11 valid", int'(cfg_valid), 1);

        // R1 reset clears flags and restores the default byte
        bus_write(8'h00, 8'h88);
        pin_reset();
        check("R1 valid after pin", int'(cfg_valid), 0);
        check("R1 err after pin", int'(order_err), 0);
        check("R1 cfg default", int'(demod_enable), 0);

        // R12 example byte, then R6 early write rejected and the next one accepted
        bus_write(8'h00, 8'h88);
        check("R12 enable", int'(demod_enable), 1);
        check("R12 qpsk", int'(bpsk_sel), 0);
        check("R12 adc", int'(ext_adc_sel), 0);
        check("R12 xtal", int'(xtal_15m), 0);
        check("R12 ratio", int'(pll_ratio), 6);
        check("R12 sysclk", int'(sysclk_half_mhz), 120);
        idle(N - 1);
        bus_write(8'h01, 8'h01);
        check("R6 early pulse", int'(soft_rst_pulse), 0);
        check("R6 early err", int'(order_err), 1);
        bus_write(8'h01, 8'h01);
        check("R6 late pulse", int'(soft_rst_pulse), 1);
        idle(1);
        check("R6 one cycle", int'(soft_rst_pulse), 0);

        // R6 first legal edge without any error
        pin_reset();
        bus_write(8'h00, 8'h88);
        idle(N);
        bus_write(8'h01, 8'h00);
        check("R6 edge pulse", int'(soft_rst_pulse), 1);
        check("R6 edge no err", int'(order_err), 0);

        // R7 configuration rewrite restarts the wait
        pin_reset();
        bus_write(8'h00, 8'h88);
        idle(10);
        bus_write(8'h00, 8'h8C);
        idle(N - 1);
        bus_write(8'h01, 8'h00);
        check("R7 restart reject", int'(soft_rst_pulse), 0);
        check("R7 restart err", int'(order_err), 1);
        bus_write(8'h01, 8'h00);
        check("R7 restart accept", int'(soft_rst_pulse), 1);

        // Program registers, then sweep all configuration bytes (R2, R3, R8-R10)
        bus_write(8'h02, 8'h00);
        bus_write(8'h03, 8'h12);
        bus_write(8'h04, 8'h34);
        bus_write(8'h05, 8'h01);
        bus_write(8'h06, 8'h03);
        for (int c = 0; c < 256; c++) begin
            bus_write(8'h00, 8'(c));
            check_cfg(c);
        end

        // R4 override sweep on a 10 MHz, ratio 9 configuration
        bus_write(8'h00, 8'h8C);
        for (int v = 1; v < 256; v++) begin
            bus_write(8'h02, 8'(v));
            check("R4 override", int'(sysclk_half_mhz), v);
        end
        bus_write(8'h02, 8'h00);
        check("R3 override cleared", int'(sysclk_half_mhz), 180);
        bus_write(8'h00, 8'h8E);
        check("R3 max clock", int'(sysclk_half_mhz), 270);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule